// File: doc/BRIEF.md
# Frame Byte Loop Counter

This block keeps track of how many bytes of an Ethernet frame are still waiting for an embedded frame-processing engine. A 16-bit remaining-byte count is loaded by the instruction path and then counts down. It moves in steps of two bytes in normal operation. When a checksum accelerator has folded several halfwords into one sum, it moves by the byte count that the accelerator reports, which is between 3 and 8. The count stops at zero and never wraps below it.

Next to the byte count, a 16-bit per-frame counter counts data-valid strobes from the start of the current frame. A start-of-frame pulse restarts this counter without a reset, so the engine can walk through several frames in a row, for example while screening frames in a low-power wake mode. The block also raises an instruction-done indication. This is true when the count has fallen to two or below while the free-run bit is set, or when a read/write instruction sees its ready input asserted.

Top module: `frame_loop_counter`

## Requirements
- R1: While reset is asserted and after it is released, `lc` and `frame_cnt` read 0 until the first load or strobe.
- R2: When `load_en` is high at a rising edge, `lc` takes `load_val` after that edge, whatever the step inputs are.
- R3: With `accel_active` low and `free_run` or `data_valid` high, `lc` drops by exactly 2 at the edge.
- R4: With neither `free_run` nor `data_valid` high and no load, `lc` keeps its value, even when `accel_active` is high.
- R5: With `accel_active` high and `free_run` or `data_valid` high, `lc` drops by the value of `accel_bytes` (3 to 8) instead of 2.
- R6: When the step is larger than `lc`, `lc` becomes 0, and it stays 0 under further steps.
- R7: `frame_cnt` rises by 1 on each edge with `data_valid` high and `sof` low, wrapping from 65535 to 0.
- R8: An edge with `sof` high sets `frame_cnt` to 1 if `data_valid` is high in that cycle and to 0 otherwise. `sof` has no effect on `lc`.
- R9: `lc_low` is a combinational output, high exactly when `lc` is 2 or less.
- R10: `instr_done` is high exactly when (`free_run` is high and `lc` is 2 or less) or (`rw_instr` and `io_ready` are both high).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| load_en | input | 1 | Load `load_val` into the byte count |
| load_val | input | 16 | Value to load |
| free_run | input | 1 | Free-run bit of the current instruction; steps every cycle |
| data_valid | input | 1 | One frame data item is present this cycle |
| accel_active | input | 1 | Checksum accelerator is supplying the step |
| accel_bytes | input | 4 | Bytes folded in by the accelerator (3 to 8) |
| sof | input | 1 | Start of a new frame |
| rw_instr | input | 1 | A read/write instruction is in progress |
| io_ready | input | 1 | Ready from the addressed read/write target |
| lc | output | 16 | Remaining byte count |
| lc_low | output | 1 | Byte count is at most 2 |
| frame_cnt | output | 16 | Data-valid strobes since the start of the frame |
| instr_done | output | 1 | Current instruction is complete |

## Verification
A wrong byte count shows on `lc` one edge after the faulty step, and on `lc_low` and `instr_done` in the same cycle, because those two are combinational. A step size that is wrong by even one byte shifts every later value, so the error persists until the next load. A stale or mis-restarted frame counter shows on `frame_cnt` one edge after the `sof` or strobe, and it persists until the next `sof`. The bench follows both counters on every cycle, so a divergence is caught at the first edge where it appears.

// File: rtl/flc_pkg.sv
package flc_pkg;
  localparam int LC_W       = 16;
  localparam int FC_W       = 16;
  localparam int BC_W       = 4;
  localparam int PAIR_STEP  = 2;
  localparam int TERM_LIMIT = 2;

  typedef enum logic {SRC_PAIR = 1'b0, SRC_ACCEL = 1'b1} step_src_e;

  // Step size in bytes chosen by the current source.
  function automatic logic [LC_W-1:0] step_of(input logic accel, input logic [BC_W-1:0] bytes);
    return accel ? LC_W'(bytes) : LC_W'(PAIR_STEP);
  endfunction

  // Subtraction that stops at zero.
  function automatic logic [LC_W-1:0] floor_sub(input logic [LC_W-1:0] a, input logic [LC_W-1:0] b);
    return (b > a) ? '0 : a - b;
  endfunction

  function automatic logic at_term(input logic [LC_W-1:0] v);
    return v <= LC_W'(TERM_LIMIT);
  endfunction
endpackage

// File: rtl/flc_step_sel.sv
module flc_step_sel
  import flc_pkg::*;
#(
  parameter int W  = LC_W,
  parameter int BW = BC_W
) (
  input  logic          accel_active,
  input  logic [BW-1:0] accel_bytes,
  output step_src_e     src,
  output logic [W-1:0]  step
);
  always_comb begin
    src  = accel_active ? SRC_ACCEL : SRC_PAIR;
    step = step_of(src == SRC_ACCEL, accel_bytes);
  end
endmodule

// File: rtl/flc_lc_reg.sv
module flc_lc_reg
  import flc_pkg::*;
#(
  parameter int W = LC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_en,
  input  logic [W-1:0] load_val,
  input  logic         step_en,
  input  logic [W-1:0] step,
  output logic [W-1:0] lc,
  output logic         floor_hit
);
  logic [W-1:0] lc_nxt;

  always_comb begin
    floor_hit = !load_en && step_en && (step > lc);
    lc_nxt    = lc;
    if (load_en)      lc_nxt = load_val;
    else if (step_en) lc_nxt = floor_sub(lc, step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lc <= '0;
    else        lc <= lc_nxt;
  end
endmodule

// File: rtl/flc_frame_ctr.sv
module flc_frame_ctr #(
  parameter int W = flc_pkg::FC_W
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sof,
  input  logic         data_valid,
  output logic [W-1:0] cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt <= '0;
    else if (sof)        cnt <= W'(data_valid);
    else if (data_valid) cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/frame_loop_counter.sv
module frame_loop_counter
  import flc_pkg::*;
(
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load_en,
  input  logic [LC_W-1:0] load_val,
  input  logic            free_run,
  input  logic            data_valid,
  input  logic            accel_active,
  input  logic [BC_W-1:0] accel_bytes,
  input  logic            sof,
  input  logic            rw_instr,
  input  logic            io_ready,
  output logic [LC_W-1:0] lc,
  output logic            lc_low,
  output logic [FC_W-1:0] frame_cnt,
  output logic            instr_done
);
  // Named internal events for the checker.
  logic            step_en;
  logic [LC_W-1:0] step_amt;
  step_src_e       step_src;
  logic            floor_hit;
  logic            rw_ack;

  assign step_en = free_run | data_valid;
  assign rw_ack  = rw_instr & io_ready;

  flc_step_sel #(.W(LC_W), .BW(BC_W)) u_sel (
    .accel_active (accel_active),
    .accel_bytes  (accel_bytes),
    .src          (step_src),
    .step         (step_amt)
  );

  flc_lc_reg #(.W(LC_W)) u_lc (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_en   (load_en),
    .load_val  (load_val),
    .step_en   (step_en),
    .step      (step_amt),
    .lc        (lc),
    .floor_hit (floor_hit)
  );

  flc_frame_ctr #(.W(FC_W)) u_fc (
    .clk        (clk),
    .rst_n      (rst_n),
    .sof        (sof),
    .data_valid (data_valid),
    .cnt        (frame_cnt)
  );

  assign lc_low     = at_term(lc);
  assign instr_done = (free_run & lc_low) | rw_ack;
endmodule

// File: rtl/flc_checker.sv
module flc_checker
  import flc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            load_en,
  input logic [LC_W-1:0] load_val,
  input logic            free_run,
  input logic            data_valid,
  input logic            accel_active,
  input logic [BC_W-1:0] accel_bytes,
  input logic            sof,
  input logic            rw_instr,
  input logic            io_ready,
  input logic [LC_W-1:0] lc,
  input logic [FC_W-1:0] frame_cnt,
  input logic            instr_done,
  input logic            floor_hit
);
  // R2
  load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> lc == $past(load_val));
  // R3
  pair_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && (free_run || data_valid) && !accel_active && lc >= LC_W'(2))
      |=> lc == LC_W'($past(lc) - LC_W'(2)));
  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && !free_run && !data_valid) |=> $stable(lc));
  // R5
  accel_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_en && (free_run || data_valid) && accel_active && lc >= LC_W'(accel_bytes))
      |=> lc == LC_W'($past(lc) - LC_W'($past(accel_bytes))));
  // R6
  floor_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    floor_hit |=> lc == '0);
  // R7
  fc_incr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!sof && data_valid) |=> frame_cnt == FC_W'($past(frame_cnt) + FC_W'(1)));
  // R8
  sof_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof |=> frame_cnt == FC_W'($past(data_valid)));
  // R10
  rw_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rw_instr && io_ready) |-> instr_done);
endmodule

bind frame_loop_counter flc_checker u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .load_en      (load_en),
  .load_val     (load_val),
  .free_run     (free_run),
  .data_valid   (data_valid),
  .accel_active (accel_active),
  .accel_bytes  (accel_bytes),
  .sof          (sof),
  .rw_instr     (rw_instr),
  .io_ready     (io_ready),
  .lc           (lc),
  .frame_cnt    (frame_cnt),
  .instr_done   (instr_done),
  .floor_hit    (floor_hit)
);

// File: tb/test_frame_loop_counter.sv
module test_frame_loop_counter;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        load_en = 1'b0;
  logic [15:0] load_val = '0;
  logic        free_run = 1'b0;
  logic        data_valid = 1'b0;
  logic        accel_active = 1'b0;
  logic [3:0]  accel_bytes = '0;
  logic        sof = 1'b0;
  logic        rw_instr = 1'b0;
  logic        io_ready = 1'b0;
  logic [15:0] lc;
  logic        lc_low;
  logic [15:0] frame_cnt;
  logic        instr_done;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  typedef struct {
    logic [15:0] lc;
    logic [15:0] fc;
    string       tag;
  } exp_t;
  exp_t q[$];

  logic [15:0] m_lc = '0;
  logic [15:0] m_fc = '0;

  always #2 clk = ~clk;

  frame_loop_counter i_frame_loop_counter (
    .clk(clk), .rst_n(rst_n), .load_en(load_en), .load_val(load_val),
    .free_run(free_run), .data_valid(data_valid), .accel_active(accel_active),
    .accel_bytes(accel_bytes), .sof(sof), .rw_instr(rw_instr), .io_ready(io_ready),
    .lc(lc), .lc_low(lc_low), .frame_cnt(frame_cnt), .instr_done(instr_done)
  );

  task automatic check16(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Driver: applies one cycle, checks combinational outputs, pushes expected state.
  task automatic drive(input logic ld, input logic [15:0] lv, input logic fr,
                       input logic dv, input logic acc, input logic [3:0] ab,
                       input logic sf, input logic rw, input logic rdy, input string tag);
    logic [15:0] st;
    exp_t e;
    @(negedge clk);
    load_en = ld; load_val = lv; free_run = fr; data_valid = dv;
    accel_active = acc; accel_bytes = ab; sof = sf; rw_instr = rw; io_ready = rdy;
    #1;
    check16("R9 lc_low", 16'(lc_low), 16'(m_lc <= 16'd2));
    check16("R10 instr_done", 16'(instr_done), 16'((fr && m_lc <= 16'd2) || (rw && rdy)));
    if (ld) m_lc = lv;
    else if (fr || dv) begin
      st = acc ? 16'(ab) : 16'd2;
      m_lc = (st > m_lc) ? 16'd0 : m_lc - st;
    end
    if (sf) m_fc = dv ? 16'd1 : 16'd0;
    else if (dv) m_fc = m_fc + 16'd1;
    e.lc = m_lc; e.fc = m_fc; e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: pops expected items after each edge.
  initial begin
    forever begin
      exp_t e;
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        e = q.pop_front();
        check16({e.tag, " lc"}, lc, e.lc);
        check16({e.tag, " frame_cnt"}, frame_cnt, e.fc);
      end
    end
  end

  initial begin
    #800000;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    #5;
    check16("R1 lc in reset", lc, 16'd0);
    check16("R1 frame_cnt in reset", frame_cnt, 16'd0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    drive(0, 16'd0, 0, 0, 0, 4'd0, 0, 0, 0, "R1");
    // R2 load, then R3 pair steps via free-run and via data-valid
    drive(1, 16'd100, 0, 0, 0, 4'd0, 0, 0, 0, "R2");
    for (int i = 0; i < 5; i++) drive(0, 16'd0, 1, 0, 0, 4'd0, 0, 0, 0, "R3");
    for (int i = 0; i < 4; i++) drive(0, 16'd0, 0, 1, 0, 4'd0, 0, 0, 0, "R3");
    // R4 idle holds, accelerator flag alone does nothing
    for (int i = 0; i < 3; i++) drive(0, 16'd0, 0, 0, 1, 4'd8, 0, 0, 0, "R4");
    // R5 accelerator step sizes 3..8
    for (int b = 3; b <= 8; b++) drive(0, 16'd0, 0, 1, 1, 4'(b), 0, 0, 0, "R5");
    for (int b = 3; b <= 8; b++) drive(0, 16'd0, 1, 0, 1, 4'(b), 0, 0, 0, "R5");
    // R2 load beats a step in the same cycle
    drive(1, 16'd5, 1, 1, 1, 4'd8, 0, 0, 0, "R2");
    // R6 step beyond count floors at zero and stays there
    drive(0, 16'd0, 1, 0, 1, 4'd8, 0, 0, 0, "R6");
    drive(0, 16'd0, 1, 0, 0, 4'd0, 0, 0, 0, "R6");
    drive(1, 16'd1, 0, 0, 0, 4'd0, 0, 0, 0, "R2");
    drive(0, 16'd0, 0, 1, 0, 4'd0, 0, 0, 0, "R6");
    // R9/R10 around the terminal boundary
    drive(1, 16'd3, 0, 0, 0, 4'd0, 0, 0, 0, "R2");
    drive(0, 16'd0, 0, 0, 0, 4'd0, 0, 0, 0, "R9");
    drive(0, 16'd0, 1, 0, 0, 4'd0, 0, 0, 0, "R10");
    drive(0, 16'd0, 1, 0, 0, 4'd0, 0, 0, 0, "R10");
    drive(1, 16'd50, 0, 0, 0, 4'd0, 0, 1, 0, "R10");
    drive(0, 16'd0, 0, 0, 0, 4'd0, 0, 1, 1, "R10");
    drive(0, 16'd0, 0, 0, 0, 4'd0, 0, 0, 1, "R10");
    // R8 restart without and with a same-cycle strobe; lc untouched
    drive(0, 16'd0, 0, 0, 0, 4'd0, 1, 0, 0, "R8");
    drive(0, 16'd0, 0, 1, 0, 4'd0, 0, 0, 0, "R7");
    drive(0, 16'd0, 0, 1, 0, 4'd0, 1, 0, 0, "R8");
    drive(0, 16'd0, 1, 0, 0, 4'd0, 0, 0, 0, "R7");
    // R7 wrap: 65536 strobes bring the count around to the same value
    for (int i = 0; i < 65536; i++) drive(0, 16'd0, 0, 1, 0, 4'd0, 0, 0, 0, "R7");
    drive(0, 16'd0, 0, 0, 0, 4'd0, 0, 0, 0, "R7");
    @(negedge clk); @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule